// File: doc/BRIEF.md
# DRAM Bank Preparation Selector

This block looks at every bank of a DRAM channel, across all ranks, and decides which banks are the best ones to open next. For each bank that has at least one request waiting, it works out when an activate could go out and when the following column command could go out. It then reports a mask of the winning banks and a flag. The flag says whether the chosen activate can be tucked in behind the data transfer that is already on the bus.

A bank counts as seamless when its column command can go out by a deadline that the caller supplies. That deadline is the latest column time that still keeps the data bus busy with no gap. Seamless banks always win. If no bank is seamless, the winners are the banks with the smallest activate time. The caller raises `start_i` for one cycle with all bank state on the inputs. Two clock edges later `done_o` pulses for one cycle, and the mask and flag stay valid until the next result.

Top module: `dram_bank_prep_eval`

## Requirements
- R1: Only banks whose pending bit is set can appear in `mask_o`. When no bank is pending, `mask_o` is zero and `hidden_o` is 0. When at least one bank is pending, `mask_o` is non-zero.
- R2: A bank's activate time is computed as follows.
  - If its row is closed (open bit 0), it is max(activate-allowed, now).
  - If its row is open (open bit 1), it is max(precharge-allowed, now) + `t_rp_i`.
- R3: A bank's column time is max(column-allowed, activate time + `t_rcd_i`). The bank is seamless when its column time is less than or equal to `col_deadline_i`; equality counts as seamless.
- R4: If any pending bank is seamless, `mask_o` holds exactly the set of pending seamless banks.
- R5: If no pending bank is seamless, `mask_o` holds exactly the pending banks whose activate time equals the minimum activate time over all pending banks. Ties all appear.
- R6: The hidden limit is max(`col_deadline_i` − `t_rcd_i`, `now_i`), where the subtraction saturates at 0. `hidden_o` is 1 when the activate time of the highest-index bank set in `mask_o` is at or below the hidden limit, and 0 otherwise.
- R7: The bank in rank r at position b within that rank maps to bit r·`BANKS_PER_RANK`+b of every per-bank vector. Each time field occupies bits [i·TW +: TW] for bank i.
- R8: All inputs are sampled only in the cycle where `start_i` is high.
  - `done_o` is high exactly two cycles later, for one cycle.
  - `mask_o` and `hidden_o` do not change while `done_o` is low.
  - Input changes after the start cycle have no effect on the result.
- R9: After reset, `done_o`, `mask_o` and `hidden_o` are all 0.
- R10: Time sums are formed without wrap-around. An open bank whose precharge-allowed time plus `t_rp_i` exceeds 2^TW−1 compares as larger than any closed bank whose time fits in TW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to evaluate the present inputs |
| bank_open_i | input | NB | Per bank: 1 when a row is currently open |
| bank_pend_i | input | NB | Per bank: 1 when some queued request targets the bank |
| act_ok_i | input | NB·TW | Per bank: earliest activate-allowed time |
| pre_ok_i | input | NB·TW | Per bank: earliest precharge-allowed time |
| col_ok_i | input | NB·TW | Per bank: earliest column-allowed time |
| now_i | input | TW | Current time |
| col_deadline_i | input | TW | Latest column time that still gives a gap-free burst |
| t_rp_i | input | DW | Precharge-to-activate delay |
| t_rcd_i | input | DW | Activate-to-column delay |
| done_o | output | 1 | One-cycle pulse: result valid |
| mask_o | output | NB | Selected banks |
| hidden_o | output | 1 | Chosen activate fits before the hidden limit |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- **Column time exactly equal to the deadline.** A strict compare would drop that bank from the seamless set.
- **Equal activate times.** An implementation that keeps only the first minimum would lose a tie from the mask.
- **Deadline smaller than the activate-to-column delay.** A wrapping subtraction would raise the hidden flag wrongly.
- **An open bank whose precharge time is close to the top of the time range.** A truncated sum would make that bank win wrongly.
- **Inputs changed right after start.** A design that does not capture its inputs would produce a mixed result.
- **Random scenes that mix open and closed banks with small times.** These drive frequent seamless/non-seamless transitions, and each result is compared against a set-based restatement of the selection rule.

// File: rtl/dram_prep_pkg.sv
package dram_prep_pkg;

  // Internal time width: wide enough for any TW <= 32 input plus two additions.
  localparam int unsigned XTW = 34;
  typedef logic [XTW-1:0] xtime_t;

  function automatic xtime_t tmax(input xtime_t a, input xtime_t b);
    return (a > b) ? a : b;
  endfunction

  // Earliest activate: closed bank waits for its own allowance, open bank
  // must first precharge.
  function automatic xtime_t act_time(input logic is_open, input xtime_t act_ok,
                                      input xtime_t pre_ok, input xtime_t now,
                                      input xtime_t trp);
    return is_open ? (tmax(pre_ok, now) + trp) : tmax(act_ok, now);
  endfunction

  function automatic xtime_t col_time(input xtime_t col_ok, input xtime_t act_at,
                                      input xtime_t trcd);
    return tmax(col_ok, act_at + trcd);
  endfunction

  // Latest activate time that keeps the column command on the deadline.
  function automatic xtime_t hidden_limit(input xtime_t deadline, input xtime_t trcd,
                                          input xtime_t now);
    xtime_t d;
    d = (deadline >= trcd) ? (deadline - trcd) : '0;
    return tmax(d, now);
  endfunction

endpackage

// File: rtl/bank_timing_calc.sv
module bank_timing_calc
  import dram_prep_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          open_i,
  input  logic [TW-1:0] act_ok_i,
  input  logic [TW-1:0] pre_ok_i,
  input  logic [TW-1:0] col_ok_i,
  input  logic [TW-1:0] now_i,
  input  logic [TW-1:0] deadline_i,
  input  logic [DW-1:0] trp_i,
  input  logic [DW-1:0] trcd_i,
  input  xtime_t        hid_lim_i,
  output xtime_t        act_at_o,
  output logic          seam_o,
  output logic          hid_ok_o
);

  xtime_t col_at;

  always_comb begin
    act_at_o = act_time(open_i, xtime_t'(act_ok_i), xtime_t'(pre_ok_i),
                        xtime_t'(now_i), xtime_t'(trp_i));
    col_at   = col_time(xtime_t'(col_ok_i), act_at_o, xtime_t'(trcd_i));
    seam_o   = (col_at <= xtime_t'(deadline_i));
    hid_ok_o = (act_at_o <= hid_lim_i);
  end

endmodule

// File: rtl/prep_fold_step.sv
module prep_fold_step
  import dram_prep_pkg::*;
#(
  parameter int unsigned NB  = 8,
  parameter int unsigned IDX = 0
) (
  input  logic [NB-1:0] mask_i,
  input  xtime_t        min_i,
  input  logic          found_i,
  input  logic          hid_i,
  input  logic          pend_i,
  input  logic          seam_i,
  input  logic          hid_ok_i,
  input  xtime_t        act_i,
  output logic [NB-1:0] mask_o,
  output xtime_t        min_o,
  output logic          found_o,
  output logic          hid_o,
  output logic          take_o
);

  logic clr;

  always_comb begin
    take_o  = pend_i && (seam_i || (!found_i && (act_i <= min_i)));
    clr     = take_o && !found_i && (seam_i || (act_i < min_i));
    mask_o  = mask_i;
    min_o   = min_i;
    found_o = found_i;
    hid_o   = hid_i;
    if (take_o) begin
      if (clr) mask_o = '0;
      mask_o[IDX] = 1'b1;
      min_o       = act_i;
      found_o     = found_i | seam_i;
      hid_o       = hid_ok_i;
    end
  end

endmodule

// File: rtl/dram_bank_prep_eval.sv
module dram_bank_prep_eval
  import dram_prep_pkg::*;
#(
  parameter int unsigned NUM_RANKS      = 2,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned TW             = 16,
  parameter int unsigned DW             = 8,
  localparam int unsigned NB            = NUM_RANKS * BANKS_PER_RANK,
  localparam int unsigned TOTW          = NB * TW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NB-1:0]   bank_open_i,
  input  logic [NB-1:0]   bank_pend_i,
  input  logic [TOTW-1:0] act_ok_i,
  input  logic [TOTW-1:0] pre_ok_i,
  input  logic [TOTW-1:0] col_ok_i,
  input  logic [TW-1:0]   now_i,
  input  logic [TW-1:0]   col_deadline_i,
  input  logic [DW-1:0]   t_rp_i,
  input  logic [DW-1:0]   t_rcd_i,
  output logic            done_o,
  output logic [NB-1:0]   mask_o,
  output logic            hidden_o
);

  // ---------------- capture stage ----------------
  logic [NB-1:0]   cap_open_q, cap_pend_q;
  logic [TOTW-1:0] cap_act_q, cap_pre_q, cap_col_q;
  logic [TW-1:0]   cap_now_q, cap_dl_q;
  logic [DW-1:0]   cap_rp_q, cap_rcd_q;
  logic            v1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_open_q <= '0;
      cap_pend_q <= '0;
      cap_act_q  <= '0;
      cap_pre_q  <= '0;
      cap_col_q  <= '0;
      cap_now_q  <= '0;
      cap_dl_q   <= '0;
      cap_rp_q   <= '0;
      cap_rcd_q  <= '0;
      v1_q       <= 1'b0;
    end else begin
      v1_q <= start_i;
      if (start_i) begin
        cap_open_q <= bank_open_i;
        cap_pend_q <= bank_pend_i;
        cap_act_q  <= act_ok_i;
        cap_pre_q  <= pre_ok_i;
        cap_col_q  <= col_ok_i;
        cap_now_q  <= now_i;
        cap_dl_q   <= col_deadline_i;
        cap_rp_q   <= t_rp_i;
        cap_rcd_q  <= t_rcd_i;
      end
    end
  end

  // ---------------- per-bank timing ----------------
  xtime_t        hid_lim;
  xtime_t        bank_act [NB];
  logic [NB-1:0] bank_seam;
  logic [NB-1:0] bank_hid_ok;

  assign hid_lim = hidden_limit(xtime_t'(cap_dl_q), xtime_t'(cap_rcd_q), xtime_t'(cap_now_q));

  // Flat index = rank * BANKS_PER_RANK + bank (R7)
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
      localparam int unsigned IDX = r * BANKS_PER_RANK + b;
      bank_timing_calc #(.TW(TW), .DW(DW)) calc_i (
        .open_i     (cap_open_q[IDX]),
        .act_ok_i   (cap_act_q[IDX*TW +: TW]),
        .pre_ok_i   (cap_pre_q[IDX*TW +: TW]),
        .col_ok_i   (cap_col_q[IDX*TW +: TW]),
        .now_i      (cap_now_q),
        .deadline_i (cap_dl_q),
        .trp_i      (cap_rp_q),
        .trcd_i     (cap_rcd_q),
        .hid_lim_i  (hid_lim),
        .act_at_o   (bank_act[IDX]),
        .seam_o     (bank_seam[IDX]),
        .hid_ok_o   (bank_hid_ok[IDX])
      );
    end
  end

  // ---------------- selection fold, ascending flat index ----------------
  logic [NB-1:0] chain_mask  [NB+1];
  xtime_t        chain_min   [NB+1];
  logic          chain_found [NB+1];
  logic          chain_hid   [NB+1];
  logic [NB-1:0] bank_take;

  assign chain_mask[0]  = '0;
  assign chain_min[0]   = '1;
  assign chain_found[0] = 1'b0;
  assign chain_hid[0]   = 1'b0;

  for (genvar g = 0; g < NB; g++) begin : g_fold
    prep_fold_step #(.NB(NB), .IDX(g)) step_i (
      .mask_i   (chain_mask[g]),
      .min_i    (chain_min[g]),
      .found_i  (chain_found[g]),
      .hid_i    (chain_hid[g]),
      .pend_i   (cap_pend_q[g]),
      .seam_i   (bank_seam[g]),
      .hid_ok_i (bank_hid_ok[g]),
      .act_i    (bank_act[g]),
      .mask_o   (chain_mask[g+1]),
      .min_o    (chain_min[g+1]),
      .found_o  (chain_found[g+1]),
      .hid_o    (chain_hid[g+1]),
      .take_o   (bank_take[g])
    );

    // R4
    seam_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain_found[g] |-> chain_found[g+1]);
    // R1
    idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_pend_q[g] |-> (chain_mask[g+1] == chain_mask[g]));
    // R4
    seam_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_pend_q[g] && bank_seam[g]) |-> (bank_take[g] && chain_mask[g+1][g]));
  end

  // ---------------- result stage ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      mask_o   <= '0;
      hidden_o <= 1'b0;
    end else begin
      done_o <= v1_q;
      if (v1_q) begin
        mask_o   <= chain_mask[NB];
        hidden_o <= chain_hid[NB];
      end
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##2 done_o);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(mask_o) && $stable(hidden_o)));
  // R1
  pend_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((mask_o & ~cap_pend_q) == '0));
  // R1
  nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (cap_pend_q != '0)) |-> (mask_o != '0));
  // R6
  empty_no_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (mask_o == '0)) |-> !hidden_o);
  // R5
  min_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && !chain_found[NB] && (chain_mask[NB] != '0)) |-> (chain_min[NB] != '1));

endmodule

// File: tb/dram_bank_prep_eval_tb_top.sv
`timescale 1ns/1ps
module dram_bank_prep_eval_tb_top;

  localparam int NB = 8;
  localparam int TW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NB-1:0]    open_v, pend_v;
  logic [NB*TW-1:0] act_v, pre_v, col_v;
  logic [TW-1:0]    now_v, dl_v;
  logic [DW-1:0]    rp_v, rcd_v;
  logic             done;
  logic [NB-1:0]    mask;
  logic             hidden;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_bank_prep_eval #(.NUM_RANKS(2), .BANKS_PER_RANK(4), .TW(TW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .bank_open_i(open_v), .bank_pend_i(pend_v),
    .act_ok_i(act_v), .pre_ok_i(pre_v), .col_ok_i(col_v),
    .now_i(now_v), .col_deadline_i(dl_v), .t_rp_i(rp_v), .t_rcd_i(rcd_v),
    .done_o(done), .mask_o(mask), .hidden_o(hidden)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint bmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  function automatic longint b_act(input int i);
    if (open_v[i]) return bmax(pre_v[i*TW +: TW], now_v) + rp_v;
    return bmax(act_v[i*TW +: TW], now_v);
  endfunction

  // Set-based restatement of the selection rule.
  task automatic expect_result(output logic [NB-1:0] m, output logic h, output bit any_seam);
    longint a [NB];
    bit s [NB];
    longint mn = 64'h7fffffffffffffff;
    longint lim;
    m = '0; h = 1'b0; any_seam = 1'b0;
    for (int i = 0; i < NB; i++) begin
      a[i] = b_act(i);
      s[i] = bmax(col_v[i*TW +: TW], a[i] + rcd_v) <= dl_v;
      if (pend_v[i] && s[i]) any_seam = 1'b1;
      if (pend_v[i] && a[i] < mn) mn = a[i];
    end
    for (int i = 0; i < NB; i++)
      if (pend_v[i]) m[i] = any_seam ? s[i] : (a[i] == mn);
    lim = bmax((dl_v >= rcd_v) ? (dl_v - rcd_v) : 0, now_v);
    for (int i = 0; i < NB; i++)
      if (m[i]) h = (a[i] <= lim);
  endtask

  task automatic clear_in();
    open_v = '0; pend_v = '0; act_v = '0; pre_v = '0; col_v = '0;
    now_v = '0; dl_v = '0; rp_v = '0; rcd_v = '0;
  endtask

  // Start, wait for result (two edges later), compare.
  task automatic run_eval(input string tag, input bit scramble);
    logic [NB-1:0] em;
    logic eh;
    bit sm;
    expect_result(em, eh, sm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      pend_v = ~pend_v; act_v = ~act_v; col_v = '0; dl_v = '1;
    end
    chk(done == 1'b0, "R8 done early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(mask == em, {tag, (sm ? " R4 mask" : " R5 mask")}, mask, em);
    chk(hidden == eh, {tag, " R6 hidden"}, hidden, eh);
    @(negedge clk);
    chk(done == 1'b0 && mask == em, "R8 hold", mask, em);
  endtask

  initial begin
    void'($urandom(32'd20240));
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(done == 0 && mask == 0 && hidden == 0, "R9 reset", {done, mask, hidden}, 0);

    // R1: nothing pending
    clear_in(); open_v = '1; dl_v = 16'd100;
    run_eval("R1 empty", 1'b0);

    // R7: rank 1, bank 1 -> bit 5 only
    clear_in(); pend_v = 8'b0010_0000; act_v[5*TW +: TW] = 16'd7;
    run_eval("R7 index", 1'b0);
    chk(mask == 8'h20, "R7 flat bit", mask, 8'h20);

    // R2: open bank and closed bank tie at 8
    clear_in(); pend_v = 8'b11; open_v = 8'b01; now_v = 16'd2; rp_v = 8'd3;
    pre_v[0 +: TW] = 16'd5; act_v[TW +: TW] = 16'd8; rcd_v = 8'd1;
    run_eval("R2 tie", 1'b0);
    chk(mask == 8'b11, "R2 open-bank act", mask, 8'b11);

    // R3: column exactly at deadline is seamless and wins over earlier act
    clear_in(); pend_v = 8'b1100; rcd_v = 8'd2; dl_v = 16'd20;
    col_v[2*TW +: TW] = 16'd21;
    act_v[3*TW +: TW] = 16'd18; col_v[3*TW +: TW] = 16'd20;
    run_eval("R3 boundary", 1'b0);
    chk(mask == 8'b1000 && hidden == 1'b1, "R3 seamless at deadline", {mask, hidden}, {8'b1000, 1'b1});

    // R4: several seamless banks mixed with non-seamless
    clear_in(); pend_v = 8'hFF; dl_v = 16'd30; rcd_v = 8'd4;
    for (int i = 0; i < NB; i++) act_v[i*TW +: TW] = (i % 2 == 0) ? 16'd10 : 16'd40;
    run_eval("R4 multi", 1'b0);
    chk(mask == 8'h55, "R4 seamless set", mask, 8'h55);

    // R6: deadline below tRCD saturates to now
    clear_in(); pend_v = 8'b1; now_v = 16'd4; dl_v = 16'd3; rcd_v = 8'd5; act_v[0 +: TW] = 16'd9;
    run_eval("R6 sat", 1'b0);
    chk(hidden == 1'b0, "R6 saturated limit", hidden, 0);

    // R10: open bank sum beyond TW bits
    clear_in(); pend_v = 8'b11; open_v = 8'b01; pre_v[0 +: TW] = 16'hFFF0; rp_v = 8'hFF;
    act_v[TW +: TW] = 16'hFFFF;
    run_eval("R10 wide", 1'b0);
    chk(mask == 8'b10, "R10 no wrap", mask, 8'b10);

    // R8: inputs scrambled right after start
    clear_in(); pend_v = 8'b0100_0001; act_v[0 +: TW] = 16'd12; act_v[6*TW +: TW] = 16'd3;
    run_eval("R8 capture", 1'b1);

    // Random scenes
    for (int n = 0; n < 400; n++) begin
      pend_v = 8'($urandom);
      open_v = 8'($urandom);
      for (int i = 0; i < NB; i++) begin
        act_v[i*TW +: TW] = 16'($urandom_range(0, 40));
        pre_v[i*TW +: TW] = 16'($urandom_range(0, 40));
        col_v[i*TW +: TW] = 16'($urandom_range(0, 50));
      end
      now_v = 16'($urandom_range(0, 15));
      dl_v  = 16'($urandom_range(0, 60));
      rp_v  = 8'($urandom_range(0, 8));
      rcd_v = 8'($urandom_range(0, 8));
      run_eval("rand", 1'b0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule